// File: doc/BRIEF.md
# External Bus Pin Multiplexer

This block sits between a chip's external bus controller and two 16-bit port pin groups, here called port A and port B. For every external access it decides which pins are driven, what value each one carries and which write and byte-high strobes are pulsed. The bus controller supplies the bus type for the current access, the write style, the access phase (address or data), the direction, the byte/word size, the address and the write data. The block does not generate bus timing or wait states, and it does not capture read data. It only routes values and strobes onto the pins.

In multiplexed mode, port A carries the address during the address phase and the write data during the data phase. In de-multiplexed mode, port B holds the address for the whole access and port A carries only data. Port B stays released unless some region of the chip is configured for a de-multiplexed bus. The write strobes take one of two forms. In the standard form there is one write strobe plus a byte-high enable. In the alternate form there are separate high-byte and low-byte write strobes. All port values and strobes are registered, so each pin reflects the inputs of the previous clock edge.

Top module: `extBusPinMux`

## Requirements
- R1: While reset is asserted, and one clock after any cycle with `accActive` low, every output-enable bit is 0, both port values are 0, and `wrN`, `bheN`, `wrhN` and `wrlN` are all 1. A released pin always carries the value 0.
- R2: The bus type is encoded as follows: `busType[0]`=1 means multiplexed and `busType[1]`=1 means a 16-bit bus. In a multiplexed address phase, one clock later port A carries `accAddr` on all 16 pins with every enable set, for either width.
- R3: In a write data phase in either mode, on a 16-bit bus, port A carries `accWData` with all enables set one clock later. On an 8-bit bus only bits 7:0 carry data and are enabled, and bits 15:8 are released.
- R4: In a read data phase (`accPhaseData`=1, `accWrite`=0), every port A pin is released one clock later.
- R5: Port B drives `accAddr` with all enables set one clock after an active de-multiplexed access (either phase) while `anyDemuxCfg`=1. In every other case, including whenever `anyDemuxCfg`=0, it is fully released.
- R6: In a de-multiplexed address phase, port A is fully released one clock later.
- R7: With `wrAltCfg`=0 (standard style), `wrN` is low one clock after a write data phase and is high otherwise. `wrhN` and `wrlN` then stay high.
- R8: `bheN` is low one clock after an active access in either phase when all three of these hold: `wrAltCfg`=0, a 16-bit bus, and either a word access (`accByte`=0) or an odd `accAddr[0]`. It is high on an 8-bit bus and in the alternate style.
- R9: With `wrAltCfg`=1 on a 16-bit bus, one clock after a write data phase `wrhN` is low for a word write or an odd-address byte write, and `wrlN` is low for a word write or an even-address byte write. `wrN` stays high.
- R10: With `wrAltCfg`=1 on an 8-bit bus, every write data phase pulses `wrlN` alone. `wrhN` and `wrN` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busType | input | 2 | Bit 1: 16-bit bus; bit 0: multiplexed |
| anyDemuxCfg | input | 1 | Some region uses a de-multiplexed bus |
| wrAltCfg | input | 1 | 1 selects separate high/low write strobes |
| accActive | input | 1 | An external access is in progress |
| accPhaseData | input | 1 | 0 address phase, 1 data phase |
| accWrite | input | 1 | Access is a write |
| accByte | input | 1 | Byte access (0 = word) |
| accAddr | input | 16 | Intra-segment address |
| accWData | input | 16 | Write data |
| portAOut | output | 16 | Port A pin values |
| portAOe | output | 16 | Port A output enables |
| portBOut | output | 16 | Port B pin values |
| portBOe | output | 16 | Port B output enables |
| wrN | output | 1 | Write strobe, active low |
| bheN | output | 1 | Byte-high enable, active low |
| wrhN | output | 1 | High-byte write strobe, active low |
| wrlN | output | 1 | Low-byte write strobe, active low |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it, because port values, enables and strobes each pass through a single register stage. The bench drives inputs on the falling edge. At that moment it computes the expected pin state from those inputs and holds it. On the next falling edge, half a period after the capturing edge, it compares every output group against that expectation. It then applies the next stimulus. During reset the expectation is forced to the idle state even when the inputs show an access, and the first compare after reset release uses the first stimulus applied.

// File: rtl/extBusPinPkg.sv
package extBusPinPkg;

  // What port A carries in the next cycle
  typedef enum logic [1:0] {
    A_IDLE = 2'd0,
    A_ADDR = 2'd1,
    A_DATA = 2'd2
  } portASelE;

  // Select strobes from control to datapath
  typedef struct packed {
    portASelE aSel;    // source for port A
    logic     aHiEn;   // upper lanes of port A take part
    logic     bDrive;  // port B carries the address
  } pinCtrlT;

endpackage

// File: rtl/extBusPinCtrl.sv
module extBusPinCtrl
  import extBusPinPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busType,
  input  logic       anyDemuxCfg,
  input  logic       wrAltCfg,
  input  logic       accActive,
  input  logic       accPhaseData,
  input  logic       accWrite,
  input  logic       accByte,
  input  logic       addrLsb,
  output pinCtrlT    pinCtrl,
  output logic       wrN,
  output logic       bheN,
  output logic       wrhN,
  output logic       wrlN
);

  logic width16, muxed, wrData, hiLane, loLane;
  logic wrNxt, bheNxt, wrhNxt, wrlNxt;

  assign width16 = busType[1];
  assign muxed   = busType[0];
  assign wrData  = accActive && accWrite && accPhaseData;
  assign hiLane  = !accByte || addrLsb;
  assign loLane  = !accByte || !addrLsb;

  // Port routing decode
  always_comb begin
    pinCtrl.aSel = A_IDLE;
    if (accActive) begin
      if (!accPhaseData) begin
        if (muxed) pinCtrl.aSel = A_ADDR;
      end else if (accWrite) begin
        pinCtrl.aSel = A_DATA;
      end
    end
    pinCtrl.aHiEn  = (pinCtrl.aSel == A_ADDR) || width16;
    pinCtrl.bDrive = accActive && !muxed && anyDemuxCfg;
  end

  // Strobe decode (active-high internally)
  always_comb begin
    wrNxt  = wrData && !wrAltCfg;
    bheNxt = accActive && !wrAltCfg && width16 && hiLane;
    wrhNxt = wrData && wrAltCfg && width16 && hiLane;
    wrlNxt = wrData && wrAltCfg && (width16 ? loLane : 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrN  <= 1'b1;
      bheN <= 1'b1;
      wrhN <= 1'b1;
      wrlN <= 1'b1;
    end else begin
      wrN  <= !wrNxt;
      bheN <= !bheNxt;
      wrhN <= !wrhNxt;
      wrlN <= !wrlNxt;
    end
  end

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accActive |=> (wrN && bheN && wrhN && wrlN));  // R1
  AST_BHE_NARROW_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !width16 |=> bheN);  // R8
  AST_ONE_STROBE_STYLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (wrhN && wrlN));  // R7
  AST_NARROW_NO_WRH: assert property (@(posedge clk) disable iff (!rstN)
    (!width16 && wrData && wrAltCfg) |=> (wrhN && !wrlN));  // R10

endmodule

// File: rtl/extBusPinData.sv
module extBusPinData
  import extBusPinPkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinCtrlT           pinCtrl,
  input  logic [PORT_W-1:0] accAddr,
  input  logic [PORT_W-1:0] accWData,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe
);

  localparam int LANES = PORT_W / 8;

  // One byte lane of port A per generate iteration
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic       laneEn;
    logic [7:0] laneVal;
    assign laneEn  = (pinCtrl.aSel != A_IDLE) && ((g == 0) || pinCtrl.aHiEn);
    assign laneVal = (pinCtrl.aSel == A_ADDR) ? accAddr[g*8 +: 8] : accWData[g*8 +: 8];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        portAOut[g*8 +: 8] <= '0;
        portAOe[g*8 +: 8]  <= '0;
      end else begin
        portAOut[g*8 +: 8] <= laneEn ? laneVal : 8'h00;
        portAOe[g*8 +: 8]  <= {8{laneEn}};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portBOut <= '0;
      portBOe  <= '0;
    end else begin
      portBOut <= pinCtrl.bDrive ? accAddr : '0;
      portBOe  <= {PORT_W{pinCtrl.bDrive}};
    end
  end

  AST_A_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (pinCtrl.aSel == A_IDLE) |=> (portAOe == '0 && portAOut == '0));  // R1
  AST_B_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    pinCtrl.bDrive |=> (portBOut == $past(accAddr)));  // R5

endmodule

// File: rtl/extBusPinMux.sv
module extBusPinMux
  import extBusPinPkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busType,
  input  logic              anyDemuxCfg,
  input  logic              wrAltCfg,
  input  logic              accActive,
  input  logic              accPhaseData,
  input  logic              accWrite,
  input  logic              accByte,
  input  logic [PORT_W-1:0] accAddr,
  input  logic [PORT_W-1:0] accWData,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  output logic              wrN,
  output logic              bheN,
  output logic              wrhN,
  output logic              wrlN
);

  localparam int HALF = PORT_W / 2;

  pinCtrlT pinCtrl;

  extBusPinCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busType      (busType),
    .anyDemuxCfg  (anyDemuxCfg),
    .wrAltCfg     (wrAltCfg),
    .accActive    (accActive),
    .accPhaseData (accPhaseData),
    .accWrite     (accWrite),
    .accByte      (accByte),
    .addrLsb      (accAddr[0]),
    .pinCtrl      (pinCtrl),
    .wrN          (wrN),
    .bheN         (bheN),
    .wrhN         (wrhN),
    .wrlN         (wrlN)
  );

  extBusPinData #(.PORT_W(PORT_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .pinCtrl  (pinCtrl),
    .accAddr  (accAddr),
    .accWData (accWData),
    .portAOut (portAOut),
    .portAOe  (portAOe),
    .portBOut (portBOut),
    .portBOe  (portBOe)
  );

  AST_PORTB_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    !anyDemuxCfg |=> (portBOe == '0));  // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (accActive && accPhaseData && !accWrite) |=> (portAOe == '0));  // R4
  AST_NARROW_HI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (accActive && accPhaseData && !busType[1]) |=> (portAOe[PORT_W-1:HALF] == '0));  // R3
  AST_DEMUX_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (accActive && !accPhaseData && !busType[0]) |=> (portAOe == '0));  // R6
  AST_MUX_ADDR_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (accActive && !accPhaseData && busType[0]) |=> (portAOut == $past(accAddr)));  // R2

endmodule

// File: tb/test_extBusPinMux.sv
module test_extBusPinMux;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busType = 2'b11;
  logic        anyDemuxCfg = 1'b0, wrAltCfg = 1'b0;
  logic        accActive = 1'b0, accPhaseData = 1'b0, accWrite = 1'b0, accByte = 1'b0;
  logic [15:0] accAddr = '0, accWData = '0;
  logic [15:0] portAOut, portAOe, portBOut, portBOe;
  logic        wrN, bheN, wrhN, wrlN;

  int compared = 0;
  int mismatched = 0;
  bit haveExp = 1'b0;

  logic [15:0] eAOut, eAOe, eBOut, eBOe;
  logic        eWr, eBhe, eWrh, eWrl;
  string       tagA, tagW;

  always #10 clk = ~clk;  // 50 MHz

  extBusPinMux i_extBusPinMux (
    .clk(clk), .rstN(rstN), .busType(busType), .anyDemuxCfg(anyDemuxCfg),
    .wrAltCfg(wrAltCfg), .accActive(accActive), .accPhaseData(accPhaseData),
    .accWrite(accWrite), .accByte(accByte), .accAddr(accAddr), .accWData(accWData),
    .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut), .portBOe(portBOe),
    .wrN(wrN), .bheN(bheN), .wrhN(wrhN), .wrlN(wrlN)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural expectation from the inputs just applied
  task automatic computeExp();
    bit w16, mx, hi, lo;
    eAOut = '0; eAOe = '0; eBOut = '0; eBOe = '0;
    eWr = 1; eBhe = 1; eWrh = 1; eWrl = 1;
    tagA = "R1"; tagW = "R1";
    if (rstN && accActive) begin
      w16 = busType[1];
      mx  = busType[0];
      hi  = !accByte || accAddr[0];
      lo  = !accByte || !accAddr[0];
      tagW = w16 ? "R9" : "R10";
      if (!accPhaseData) begin
        if (mx) begin eAOut = accAddr; eAOe = 16'hFFFF; tagA = "R2"; end
        else tagA = "R6";
      end else if (!accWrite) begin
        tagA = "R4";
      end else begin
        tagA = "R3";
        if (w16) begin eAOut = accWData; eAOe = 16'hFFFF; end
        else begin eAOut = {8'h00, accWData[7:0]}; eAOe = 16'h00FF; end
      end
      if (!mx && anyDemuxCfg) begin eBOut = accAddr; eBOe = 16'hFFFF; end
      if (!wrAltCfg && w16 && hi) eBhe = 0;
      if (accWrite && accPhaseData) begin
        if (!wrAltCfg) eWr = 0;
        else if (w16) begin eWrh = !hi; eWrl = !lo; end
        else eWrl = 0;
      end
    end
  endtask

  task automatic compareAll();
    check({portAOut, portAOe} == {eAOut, eAOe}, tagA, "portA out/oe",
          {portAOut, portAOe}, {eAOut, eAOe});
    check({portBOut, portBOe} == {eBOut, eBOe}, "R5", "portB out/oe",
          {portBOut, portBOe}, {eBOut, eBOe});
    check(wrN == eWr, "R7", "wrN", 32'(wrN), 32'(eWr));
    check(bheN == eBhe, "R8", "bheN", 32'(bheN), 32'(eBhe));
    check({wrhN, wrlN} == {eWrh, eWrl}, tagW, "wrhN/wrlN",
          32'({wrhN, wrlN}), 32'({eWrh, eWrl}));
  endtask

  // One cycle: compare previous expectation, then apply new stimulus
  task automatic step(input bit rst, input logic [1:0] bt, input bit dmx, input bit alt,
                      input bit act, input bit ph, input bit wr, input bit byt,
                      input logic [15:0] adr, input logic [15:0] dat);
    @(negedge clk);
    if (haveExp) compareAll();
    rstN = rst; busType = bt; anyDemuxCfg = dmx; wrAltCfg = alt;
    accActive = act; accPhaseData = ph; accWrite = wr; accByte = byt;
    accAddr = adr; accWData = dat;
    computeExp();
    haveExp = 1'b1;
  endtask

  initial begin
    // R1: reset dominates an active write request
    for (int i = 0; i < 3; i++)
      step(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h1235, 16'hBEEF);
    step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    // Exhaustive sweep of modes, phases, directions, sizes, address parity
    for (int c = 0; c < 256; c++) begin
      logic [15:0] a;
      a = 16'($urandom);
      a[0] = c[7];
      step(1'b1, c[1:0], c[2], c[3], 1'b1, c[4], c[5], c[6], a, 16'($urandom));
      // R1: idle cycle between accesses
      if (c % 8 == 0)
        step(1'b1, c[1:0], c[2], c[3], 1'b0, c[4], c[5], c[6], 16'($urandom), 16'($urandom));
    end
    // R10 / R9 / R8 directed corners
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0003, 16'h00A5);
    step(1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0003, 16'hA500);
    step(1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0004, 16'h005A);
    step(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0004, 16'h0000);
    // Random traffic
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(1'b1, r[1:0], r[2], r[3], r[4] | r[5], r[6], r[7], r[8],
           16'($urandom), 16'($urandom));
    end
    // Mid-run reset (R1)
    step(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
    step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule